// File: doc/BRIEF.md
# CAN Bit-Timing Parameter Solver

This unit turns a clock frequency, a peripheral clock divider code and a wanted bus bit rate into a packed 32-bit bit-timing word. It first works out how many clock ticks make up one bit. It then searches for a baud-rate prescaler and a segment index whose product matches that tick count exactly. A small table turns the winning index into two phase-segment codes, which put the sample point close to 75% of the bit.

A request is handed over with a one-cycle `start` pulse while `busy` is low. The unit then works through its steps on its own:

- one iterative division to get the ticks per bit;
- a second division to get the first prescaler to try;
- a search that tests one candidate per cycle.

When the search ends, the unit gives a one-cycle `done` pulse together with the result. If no exact match exists, or the requested bit rate is zero, the result is all ones.

Top module: `bt_solver`

## Requirements
- R1: The tick count equals floor(sys_clk_val / (M × bit_rate)), where M depends on pclk_code: code 0 gives M=4, code 1 gives M=1, code 2 gives M=2 and code 3 gives M=6.
- R2: The prescaler starts at floor(ticks/24). While it is below floor(ticks/4), it is incremented and then tried. Because the search stops at the first match, the result uses the smallest matching prescaler.
- R3: For each prescaler value p, indices i are tried from 22 down to 1. A match needs (i+3)×(p+1) to equal the tick count exactly, so for one prescaler the largest matching index wins.
- R4: The index i selects a pair (first-segment code, second-segment code). For i = 0 to 22 the pairs are: (0,0) (1,0) (2,0) (3,0) (3,1) (4,1) (5,1) (6,1) (6,2) (7,2) (8,2) (9,2) (9,3) (A,3) (B,3) (C,3) (D,3) (D,4) (E,4) (F,4) (F,5) (F,6) (F,7), written in hex.
- R5: On a match, the word has these fields:
  - bits 22:20: the second-segment code;
  - bits 19:16: the first-segment code;
  - bits 15:14: the sjw input;
  - bits 9:0: the low ten bits of the prescaler;
  - all other bits: zero.
- R6: When no prescaler and index pair matches, including a tick count below 4, the word is 0xFFFFFFFF.
- R7: A bit_rate of zero completes with the word 0xFFFFFFFF on the cycle after start, and the unit does not stall.
- R8: done is high for exactly one cycle per accepted request. timing_word holds its value until the next result.
- R9: start is ignored while busy is high. It neither changes the result in progress nor produces an extra done.
- R10: After reset, busy, done and timing_word are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while busy is low |
| sys_clk_val | input | 32 | Clock frequency (the dividend) |
| pclk_code | input | 2 | Peripheral clock divider code |
| bit_rate | input | 32 | Target bit rate |
| sjw | input | 2 | Jump width code placed in the output word |
| busy | output | 1 | High while a request is being solved |
| done | output | 1 | One-cycle pulse when timing_word is updated |
| timing_word | output | 32 | Packed bit-timing result, or all ones on failure |

## Verification
Two events can meet in the same cycle: a fresh start pulse can arrive while a search is still running, and the end of a run raises done. The bench provokes this by pulsing start with a zero bit rate partway through a long solve. A zero-rate request would normally complete on the very next cycle, so if it were wrongly accepted, an extra done pulse or an all-ones word would show up. The scoreboard judges the run by requiring exactly one done pulse, carrying the word the bench model computed for the original operands.

// File: rtl/bt_pkg.sv
// Package for the bit-timing solver: shared widths, state types, field
// positions of the packed word and the divider-code multiplier function.
// Assumes: all users compile this file first.
package bt_pkg;
    localparam int IDX_W    = 5;
    localparam int IDX_TOP  = 22;
    localparam int SEG1_LSB = 16;
    localparam int SEG2_LSB = 20;
    localparam int SJW_LSB  = 14;
    localparam int BRP_BITS = 10;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_STEP,
        SR_TRY
    } srch_state_t;

    typedef enum logic [1:0] {
        TP_IDLE,
        TP_DIV_TICKS,
        TP_DIV_START,
        TP_SEARCH
    } top_state_t;

    // Multiplier selected by the peripheral clock divider code.
    function automatic logic [2:0] pclk_mult(input logic [1:0] code);
        case (code)
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            2'd3:    return 3'd6;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bt_divider.sv
// Restoring iterative divider: one quotient bit per cycle, N cycles per
// division. Assumes the divisor is non-zero (the caller filters zero) and
// that go is only pulsed while busy is low.
module bt_divider #(
    parameter int N = 32,
    parameter int D = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient
);
    localparam int CW = $clog2(N + 1);

    logic [D:0]   rem_q;
    logic [N-1:0] quo_q;
    logic [D-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic [D:0]   trial;
    logic         fits;

    // Shift the next dividend bit into the partial remainder and compare.
    always_comb begin
        trial = {rem_q[D-1:0], quo_q[N-1]};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Iteration register: load on go, then one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(N);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? (trial - {1'b0, dvs_q}) : trial;
                quo_q <= {quo_q[N-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R1
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/bt_seg_lut.sv
// Segment-code lookup: maps a segment index (0..22) to the pair of
// phase-segment codes that keeps the sample point near 75%.
// Assumes: indices above 22 never occur; they return zeros.
module bt_seg_lut (
    input  logic [4:0] idx,
    output logic [3:0] seg1,
    output logic [2:0] seg2
);
    // Fixed 23-entry table, decoded combinationally.
    always_comb begin
        case (idx)
            5'd0:  begin seg1 = 4'h0; seg2 = 3'd0; end
            5'd1:  begin seg1 = 4'h1; seg2 = 3'd0; end
            5'd2:  begin seg1 = 4'h2; seg2 = 3'd0; end
            5'd3:  begin seg1 = 4'h3; seg2 = 3'd0; end
            5'd4:  begin seg1 = 4'h3; seg2 = 3'd1; end
            5'd5:  begin seg1 = 4'h4; seg2 = 3'd1; end
            5'd6:  begin seg1 = 4'h5; seg2 = 3'd1; end
            5'd7:  begin seg1 = 4'h6; seg2 = 3'd1; end
            5'd8:  begin seg1 = 4'h6; seg2 = 3'd2; end
            5'd9:  begin seg1 = 4'h7; seg2 = 3'd2; end
            5'd10: begin seg1 = 4'h8; seg2 = 3'd2; end
            5'd11: begin seg1 = 4'h9; seg2 = 3'd2; end
            5'd12: begin seg1 = 4'h9; seg2 = 3'd3; end
            5'd13: begin seg1 = 4'hA; seg2 = 3'd3; end
            5'd14: begin seg1 = 4'hB; seg2 = 3'd3; end
            5'd15: begin seg1 = 4'hC; seg2 = 3'd3; end
            5'd16: begin seg1 = 4'hD; seg2 = 3'd3; end
            5'd17: begin seg1 = 4'hD; seg2 = 3'd4; end
            5'd18: begin seg1 = 4'hE; seg2 = 3'd4; end
            5'd19: begin seg1 = 4'hF; seg2 = 3'd4; end
            5'd20: begin seg1 = 4'hF; seg2 = 3'd5; end
            5'd21: begin seg1 = 4'hF; seg2 = 3'd6; end
            5'd22: begin seg1 = 4'hF; seg2 = 3'd7; end
            default: begin seg1 = 4'h0; seg2 = 3'd0; end
        endcase
    end
endmodule

// File: rtl/bt_search.sv
// Exact-match search engine. From a start prescaler, it increments the
// prescaler while it is below the limit, then tries indices 22 down to 1,
// one per cycle, until (idx+3)*(prescaler+1) equals the tick count.
// Assumes ticks, brp_init and brp_limit stay stable while the search runs.
module bt_search
    import bt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [N-1:0]     ticks,
    input  logic [N-1:0]     brp_init,
    input  logic [N-1:0]     brp_limit,
    output logic             done,
    output logic             hit,
    output logic [N-1:0]     brp,
    output logic [IDX_W-1:0] idx
);
    localparam int PW = N + IDX_W + 2;

    srch_state_t   st_q;
    logic [PW-1:0] cand;

    // Candidate product for the index and prescaler under trial.
    always_comb begin
        cand = PW'(PW'(idx) + PW'(3)) * (PW'(brp) + PW'(1));
    end

    // Search sequencer: step the prescaler, then sweep the index downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SR_IDLE;
            done <= 1'b0;
            hit  <= 1'b0;
            brp  <= '0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SR_IDLE: begin
                    if (go) begin
                        brp  <= brp_init;
                        hit  <= 1'b0;
                        st_q <= SR_STEP;
                    end
                end
                SR_STEP: begin
                    if (brp < brp_limit) begin
                        brp  <= brp + N'(1);
                        idx  <= IDX_W'(IDX_TOP);
                        st_q <= SR_TRY;
                    end else begin
                        done <= 1'b1;
                        hit  <= 1'b0;
                        st_q <= SR_IDLE;
                    end
                end
                SR_TRY: begin
                    if (cand == PW'(ticks)) begin
                        done <= 1'b1;
                        hit  <= 1'b1;
                        st_q <= SR_IDLE;
                    end else if (idx == IDX_W'(1)) begin
                        st_q <= SR_STEP;
                    end else begin
                        idx <= idx - IDX_W'(1);
                    end
                end
                default: st_q <= SR_IDLE;
            endcase
        end
    end

    // R3
    hit_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (cand == PW'(ticks)) && (idx >= IDX_W'(1)) && (idx <= IDX_W'(IDX_TOP)));

    // R2
    brp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (brp > brp_init) && (brp <= brp_limit));
endmodule

// File: rtl/bt_solver.sv
// Top of the bit-timing solver. It sequences two divisions (the tick count,
// then the first prescaler) and the exact-match search, and finally packs
// the bit-timing word. A zero bit rate fails at once.
// Assumes start is a pulse; it is only honoured while busy is low.
module bt_solver
    import bt_pkg::*;
#(
    parameter int CLK_W  = 32,
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CLK_W-1:0]  sys_clk_val,
    input  logic [1:0]        pclk_code,
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [1:0]        sjw,
    output logic              busy,
    output logic              done,
    output logic [31:0]       timing_word
);
    localparam int DW = RATE_W + 3;

    top_state_t       st_q;
    logic [CLK_W-1:0] div_a_q;
    logic [DW-1:0]    div_b_q;
    logic             div_go_q;
    logic             div_busy, div_done;
    logic [CLK_W-1:0] div_quo;
    logic [CLK_W-1:0] ticks_q;
    logic [CLK_W-1:0] brp_init_q;
    logic [CLK_W-1:0] brp_limit;
    logic             srch_go_q;
    logic             srch_done, srch_hit;
    logic [CLK_W-1:0] srch_brp;
    logic [IDX_W-1:0] srch_idx;
    logic [3:0]       seg1;
    logic [2:0]       seg2;
    logic [1:0]       sjw_q;
    logic [DW-1:0]    rate_prod;
    logic [31:0]      packed_word;

    bt_divider #(.N(CLK_W), .D(DW)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go_q),
        .dividend (div_a_q),
        .divisor  (div_b_q),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    bt_search #(.N(CLK_W)) i_srch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (srch_go_q),
        .ticks     (ticks_q),
        .brp_init  (brp_init_q),
        .brp_limit (brp_limit),
        .done      (srch_done),
        .hit       (srch_hit),
        .brp       (srch_brp),
        .idx       (srch_idx)
    );

    bt_seg_lut i_lut (
        .idx  (srch_idx),
        .seg1 (seg1),
        .seg2 (seg2)
    );

    // Divisor product and stop bound derived from the held operands.
    always_comb begin
        rate_prod = DW'(pclk_mult(pclk_code)) * DW'(bit_rate);
        brp_limit = ticks_q >> 2;
    end

    // Field packing of a successful search.
    always_comb begin
        packed_word = '0;
        packed_word[SEG2_LSB +: 3]     = seg2;
        packed_word[SEG1_LSB +: 4]     = seg1;
        packed_word[SJW_LSB +: 2]      = sjw_q;
        packed_word[0 +: BRP_BITS]     = srch_brp[BRP_BITS-1:0];
    end

    // Request sequencer: divide, divide, search, then publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= TP_IDLE;
            div_a_q     <= '0;
            div_b_q     <= '0;
            div_go_q    <= 1'b0;
            srch_go_q   <= 1'b0;
            ticks_q     <= '0;
            brp_init_q  <= '0;
            sjw_q       <= '0;
            done        <= 1'b0;
            timing_word <= '0;
        end else begin
            div_go_q  <= 1'b0;
            srch_go_q <= 1'b0;
            done      <= 1'b0;
            case (st_q)
                TP_IDLE: begin
                    if (start) begin
                        sjw_q <= sjw;
                        if (bit_rate == '0) begin
                            timing_word <= '1;
                            done        <= 1'b1;
                        end else begin
                            div_a_q  <= sys_clk_val;
                            div_b_q  <= rate_prod;
                            div_go_q <= 1'b1;
                            st_q     <= TP_DIV_TICKS;
                        end
                    end
                end
                TP_DIV_TICKS: begin
                    if (div_done) begin
                        ticks_q  <= div_quo;
                        div_a_q  <= div_quo;
                        div_b_q  <= DW'(24);
                        div_go_q <= 1'b1;
                        st_q     <= TP_DIV_START;
                    end
                end
                TP_DIV_START: begin
                    if (div_done) begin
                        brp_init_q <= div_quo;
                        srch_go_q  <= 1'b1;
                        st_q       <= TP_SEARCH;
                    end
                end
                TP_SEARCH: begin
                    if (srch_done) begin
                        timing_word <= srch_hit ? packed_word : '1;
                        done        <= 1'b1;
                        st_q        <= TP_IDLE;
                    end
                end
                default: st_q <= TP_IDLE;
            endcase
        end
    end

    assign busy = (st_q != TP_IDLE);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sjw_q) && !done);

    // R5
    word_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (timing_word != '1)) |-> (timing_word[31:23] == '0) && (timing_word[13:10] == '0));

    // R7
    zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (bit_rate == '0)) |=> done && (timing_word == '1));

    // R1
    div_idle_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_go_q |-> !div_busy);
endmodule

// File: tb/test_bt_solver.sv
// Scoreboard bench: the driver pushes model results into a queue, and the
// monitor pops one entry on each done pulse and compares it.
module test_bt_solver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] sys_clk_val = '0;
    logic [1:0]  pclk_code = '0;
    logic [31:0] bit_rate = '0;
    logic [1:0]  sjw = '0;
    logic        busy, done;
    logic [31:0] timing_word;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = '0;

    bt_solver i_bt_solver (
        .clk(clk), .rst_n(rst_n), .start(start), .sys_clk_val(sys_clk_val),
        .pclk_code(pclk_code), .bit_rate(bit_rate), .sjw(sjw),
        .busy(busy), .done(done), .timing_word(timing_word)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Segment-code pair per index, as listed in R4.
    function automatic logic [6:0] seg_pair(input int i);
        logic [3:0] s1[23] = '{4'h0,4'h1,4'h2,4'h3,4'h3,4'h4,4'h5,4'h6,4'h6,4'h7,4'h8,4'h9,
                               4'h9,4'hA,4'hB,4'hC,4'hD,4'hD,4'hE,4'hF,4'hF,4'hF,4'hF};
        logic [2:0] s2[23] = '{3'd0,3'd0,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1,3'd2,3'd2,3'd2,3'd2,
                               3'd3,3'd3,3'd3,3'd3,3'd3,3'd4,3'd4,3'd4,3'd5,3'd6,3'd7};
        return {s2[i], s1[i]};
    endfunction

    // Expected word from requirements R1 to R7.
    function automatic logic [31:0] model(input logic [31:0] sys, input logic [1:0] code,
                                          input logic [31:0] rate, input logic [1:0] jw);
        longint m, t, b, lim;
        logic [6:0] sp;
        logic [31:0] w;
        m = (code == 2'd0) ? 4 : (code == 2'd1) ? 1 : (code == 2'd2) ? 2 : 6;
        if (rate == 0) return 32'hFFFF_FFFF;
        t = longint'(sys) / (m * longint'(rate));
        b = t / 24;
        lim = t / 4;
        while (b < lim) begin
            b++;
            for (int i = 22; i >= 1; i--) begin
                if (longint'(i + 3) * (b + 1) == t) begin
                    sp = seg_pair(i);
                    w = '0;
                    w[22:20] = sp[6:4];
                    w[19:16] = sp[3:0];
                    w[15:14] = jw;
                    w[9:0]   = b[9:0];
                    return w;
                end
            end
        end
        return 32'hFFFF_FFFF;
    endfunction

    // Driver: wait until idle, push the expectation, pulse start, await done.
    task automatic run_case(input logic [31:0] sys, input logic [1:0] code,
                            input logic [31:0] rate, input logic [1:0] jw, input string tag);
        int seen;
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_q.push_back(model(sys, code, rate, jw));
        tag_q.push_back(tag);
        seen = n_done;
        sys_clk_val = sys; pclk_code = code; bit_rate = rate; sjw = jw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done == seen) @(negedge clk);
    endtask

    // Monitor: on each done pulse pop one expected word and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", timing_word, 32'h0);
            end else begin
                last_exp = exp_q.pop_front();
                check(timing_word == last_exp, tag_q.pop_front(), timing_word, last_exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R8 watchdog expired actual=%h expected=done", timing_word);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R10 busy after reset", {31'b0, busy}, 32'h0);
        check(done == 1'b0, "R10 done after reset", {31'b0, done}, 32'h0);
        check(timing_word == 32'h0, "R10 word after reset", timing_word, 32'h0);

        // ticks 120 -> prescaler 7, index 12
        check(model(32'd48_000_000, 2'd0, 32'd100_000, 2'd1) == 32'h0039_4007,
              "R3 model self-check", model(32'd48_000_000, 2'd0, 32'd100_000, 2'd1), 32'h0039_4007);
        run_case(32'd48_000_000, 2'd0, 32'd100_000, 2'd1, "R3 ticks 120");
        repeat (3) @(negedge clk);
        check(timing_word == 32'h0039_4007 && !done, "R8 word held", timing_word, 32'h0039_4007);

        run_case(32'd10, 2'd1, 32'd1, 2'd2, "R4 ticks 10");
        check(timing_word == 32'h0002_8001, "R4 index 2 pair", timing_word, 32'h0002_8001);
        run_case(32'd7_200_000, 2'd3, 32'd100_000, 2'd3, "R1 code 3");
        run_case(32'd1000, 2'd2, 32'd3, 2'd0, "R1 code 2 truncation");
        run_case(32'd600, 2'd1, 32'd1, 2'd1, "R2 ticks 600");
        run_case(32'd127, 2'd1, 32'd1, 2'd1, "R6 prime ticks");
        run_case(32'd3, 2'd1, 32'd1, 2'd0, "R6 ticks below 4");
        run_case(32'd27500, 2'd1, 32'd1, 2'd2, "R5 prescaler above ten bits");
        run_case(32'd5_000_000, 2'd0, 32'd0, 2'd1, "R7 zero rate");
        check(timing_word == 32'hFFFF_FFFF, "R7 all ones", timing_word, 32'hFFFF_FFFF);

        // R9: spurious zero-rate start in the middle of a long solve
        @(negedge clk);
        exp_q.push_back(model(32'd27500, 2'd1, 32'd1, 2'd1));
        tag_q.push_back("R9 result kept");
        seen = n_done;
        sys_clk_val = 32'd27500; pclk_code = 2'd1; bit_rate = 32'd1; sjw = 2'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        bit_rate = 32'd0; sjw = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done == seen) @(negedge clk);
        repeat (5) @(negedge clk);
        check(n_done == seen + 1, "R9 single done", n_done, seen + 1);
        check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule